// File: doc/BRIEF.md
# ADC Code-Density Histogram Engine

The engine builds a histogram of the codes produced by an analog-to-digital converter. A start command first zeroes every bin of a single-port count memory. The engine then takes samples from the converter bus, qualified by a data-ready strobe. Each sample is reduced to a bin address, and that bin's stored count is read, incremented and written back. Because one update takes several cycles, the engine counts one sample and discards the next eleven.

Accumulation ends as soon as any one bin reaches a limit chosen at start. The engine then streams every bin count out in ascending address order, one per cycle. After the last count it raises a done flag. A downstream transmitter or analysis stage consumes the stream. The width of the converter and the limit are latched when the run starts.

The count memory sits inside the block behind a port shaped like an external SRAM, and that port is visible at the outputs. The bin count is a parameter. With the default setting the memory holds 1024 bins of 24 bits, and a build for 32768 bins sets `BIN_BITS` to 15.

Top module: `hist_engine`

## Requirements
- R1: While reset is held and after it is released, the engine makes no memory write, keeps `out_valid` low and keeps `done` low until a start command arrives.
- R2: A start command sets every bin to zero before counting begins. Samples offered during that clearing phase are not counted.
- R3: The converter word arrives right-justified on an 18-bit bus. `width_sel` gives its width: 00 is 18 bits, 01 is 16, 10 is 14 and 11 is 12. Bus bits above the selected width are forced to zero.
- R4: The top bit of the width-limited code is inverted, giving offset binary. The bin address is the top `BIN_BITS` bits of the resulting 18-bit field.
- R5: Each counted sample makes one read of its bin, then in the next cycle one write of the stored value plus one to the same address. An update write is never directly preceded by another write.
- R6: After clearing, the first data-ready pulse is counted. The following 11 pulses are discarded, the next one is counted, and this pattern repeats.
- R7: `max_sel` picks the limit: 00 is `MAX_TOP`, 01 is half of it, 10 a quarter and 11 an eighth. Counting stops on the update whose incremented value equals the limit, so the limiting bin ends exactly at the limit and no write exceeds `MAX_TOP`.
- R8: After counting stops, all bins are presented one per cycle in ascending address order on `out_bin`/`out_count`, qualified by `out_valid`. The memory is not written during this phase.
- R9: `done` rises in the cycle after the last bin is presented and stays high until the next start command.
- R10: A start command that arrives while the engine is clearing, counting or reading out has no effect.
- R11: `width_sel` and `max_sel` are captured at the start command. Changes to them during a run have no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_code | input | 18 | Right-justified converter word |
| adc_rdy | input | 1 | Data-ready strobe, one sample per high cycle |
| width_sel | input | 2 | Converter width select |
| max_sel | input | 2 | Bin limit select |
| start | input | 1 | Start pulse: clear, count, read out |
| mem_addr | output | BIN_BITS | Count memory address |
| mem_we | output | 1 | Count memory write enable |
| mem_wdata | output | CNT_W | Count memory write data |
| out_valid | output | 1 | A bin count is presented this cycle |
| out_bin | output | BIN_BITS | Address of the presented bin |
| out_count | output | CNT_W | Count of the presented bin |
| done | output | 1 | Readout finished |

## Verification
The assertions assume that `MAX_TOP` fits in the count width. They also assume that the limit is reachable, which the stimulus ensures: each run ends through a bin hitting its limit, and no long-running bins are left in memory. They further assume that readout and writes never overlap, which holds only if start is not honoured mid-run. The bench drives start in the middle of a run to exercise that case. Stimulus changes only on the falling edge. Data-ready is driven at random during clearing and counting, but never in the cycles around the handover from clearing to counting, so the bench's count of pulses lines up with the engine's.

// File: rtl/hist_pkg.sv
package hist_pkg;

  localparam int FIELD_W = 18;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLR,
    ST_RUN,
    ST_LOOK,
    ST_UPD,
    ST_OUT,
    ST_DONE
  } hist_state_e;

  // Number of valid converter bits for a width select code.
  function automatic int unsigned code_bits(input logic [1:0] wsel);
    return FIELD_W - 2 * int'(wsel);
  endfunction

  // Zero the unused upper bits, then flip the top valid bit.
  function automatic logic [FIELD_W-1:0] align_code(input logic [FIELD_W-1:0] raw,
                                                    input logic [1:0]         wsel);
    logic [FIELD_W-1:0] keep;
    logic [FIELD_W-1:0] flip;
    int unsigned        nb;
    nb   = code_bits(wsel);
    keep = (FIELD_W'(1) << nb) - FIELD_W'(1);
    flip = FIELD_W'(1) << (nb - 1);
    return (raw & keep) ^ flip;
  endfunction

endpackage

// File: rtl/hist_code_map.sv
module hist_code_map
  import hist_pkg::*;
#(
  parameter int BIN_BITS = 10
) (
  input  logic [FIELD_W-1:0]  raw_code,
  input  logic [1:0]          wsel,
  output logic [BIN_BITS-1:0] bin_addr
);

  localparam int LOW_BITS = FIELD_W - BIN_BITS;

  logic [FIELD_W-1:0] aligned;

  always_comb begin
    aligned  = align_code(raw_code, wsel);
    bin_addr = aligned[FIELD_W-1:LOW_BITS];
  end

endmodule

// File: rtl/hist_ram.sv
module hist_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) begin
      store[addr] <= wdata;
    end
    rdata_q <= store[addr];
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/hist_ctrl.sv
module hist_ctrl
  import hist_pkg::*;
#(
  parameter int BIN_BITS = 10,
  parameter int CNT_W    = 24,
  parameter int MAX_TOP  = 16384,
  parameter int SKIP_N   = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                rdy,
  input  logic [1:0]          width_sel,
  input  logic [1:0]          max_sel,
  input  logic [BIN_BITS-1:0] bin_in,
  input  logic [CNT_W-1:0]    ram_rdata,
  output logic [1:0]          cfg_wsel,
  output logic [BIN_BITS-1:0] ram_addr,
  output logic                ram_we,
  output logic [CNT_W-1:0]    ram_wdata,
  output logic                out_valid,
  output logic [BIN_BITS-1:0] out_bin,
  output logic                done
);

  localparam int                  SKIP_W   = $clog2(SKIP_N + 1);
  localparam logic [BIN_BITS-1:0] LAST_BIN = {BIN_BITS{1'b1}};
  localparam logic [CNT_W-1:0]    TOP_CNT  = CNT_W'(MAX_TOP);
  localparam logic [SKIP_W-1:0]   SKIP_LD  = SKIP_W'(SKIP_N);

  hist_state_e         state_q, state_d;
  logic [BIN_BITS-1:0] addr_q, addr_d;
  logic [BIN_BITS-1:0] bin_q, bin_d;
  logic [SKIP_W-1:0]   skip_q, skip_d;
  logic [1:0]          wcfg_q, mcfg_q;
  logic                cfg_en;
  logic                ov_q;
  logic [BIN_BITS-1:0] obin_q;
  logic                done_q;

  logic [CNT_W-1:0]    limit;
  logic [CNT_W-1:0]    incr;
  logic                idle_like;
  logic                counting;
  logic                take;

  always_comb begin
    limit     = TOP_CNT >> mcfg_q;
    incr      = ram_rdata + CNT_W'(1);
    idle_like = (state_q == ST_IDLE) || (state_q == ST_DONE);
    counting  = (state_q == ST_RUN) || (state_q == ST_LOOK) || (state_q == ST_UPD);
    take      = (state_q == ST_RUN) && rdy && (skip_q == '0);
    cfg_en    = idle_like && start;
  end

  // Next-state and memory port logic.
  always_comb begin
    state_d   = state_q;
    addr_d    = addr_q;
    bin_d     = bin_q;
    skip_d    = skip_q;
    ram_addr  = addr_q;
    ram_we    = 1'b0;
    ram_wdata = '0;

    // Discard window runs through the update cycles.
    if (counting && rdy && (skip_q != '0)) begin
      skip_d = skip_q - SKIP_W'(1);
    end

    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          state_d = ST_CLR;
          addr_d  = '0;
        end
      end
      ST_CLR: begin
        ram_we    = 1'b1;
        ram_wdata = '0;
        if (addr_q == LAST_BIN) begin
          state_d = ST_RUN;
          skip_d  = '0;
        end else begin
          addr_d = addr_q + BIN_BITS'(1);
        end
      end
      ST_RUN: begin
        if (take) begin
          bin_d   = bin_in;
          skip_d  = SKIP_LD;
          state_d = ST_LOOK;
        end
      end
      ST_LOOK: begin
        ram_addr = bin_q;
        state_d  = ST_UPD;
      end
      ST_UPD: begin
        ram_addr  = bin_q;
        ram_we    = 1'b1;
        ram_wdata = incr;
        if (incr == limit) begin
          state_d = ST_OUT;
          addr_d  = '0;
        end else begin
          state_d = ST_RUN;
        end
      end
      ST_OUT: begin
        ram_addr = addr_q;
        if (addr_q == LAST_BIN) begin
          state_d = ST_DONE;
        end else begin
          addr_d = addr_q + BIN_BITS'(1);
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      bin_q   <= '0;
      skip_q  <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      bin_q   <= bin_d;
      skip_q  <= skip_d;
    end
  end

  // Configuration captured only at an accepted start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcfg_q <= '0;
      mcfg_q <= '0;
    end else if (cfg_en) begin
      wcfg_q <= width_sel;
      mcfg_q <= max_sel;
    end
  end

  // Readout qualifier aligned with the one-cycle memory read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q   <= 1'b0;
      obin_q <= '0;
      done_q <= 1'b0;
    end else begin
      ov_q   <= (state_q == ST_OUT);
      obin_q <= addr_q;
      done_q <= (state_q == ST_DONE);
    end
  end

  assign cfg_wsel  = wcfg_q;
  assign out_valid = ov_q;
  assign out_bin   = obin_q;
  assign done      = done_q;

endmodule

// File: rtl/hist_engine.sv
module hist_engine
  import hist_pkg::*;
#(
  parameter int BIN_BITS = 10,
  parameter int CNT_W    = 24,
  parameter int MAX_TOP  = 16384,
  parameter int SKIP_N   = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [17:0]         adc_code,
  input  logic                adc_rdy,
  input  logic [1:0]          width_sel,
  input  logic [1:0]          max_sel,
  input  logic                start,
  output logic [BIN_BITS-1:0] mem_addr,
  output logic                mem_we,
  output logic [CNT_W-1:0]    mem_wdata,
  output logic                out_valid,
  output logic [BIN_BITS-1:0] out_bin,
  output logic [CNT_W-1:0]    out_count,
  output logic                done
);

  logic                rst_meta_q, rst_sync_q;
  logic [1:0]          wsel_cfg;
  logic [BIN_BITS-1:0] bin_addr;
  logic [CNT_W-1:0]    ram_rdata;

  // Asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  hist_code_map #(
    .BIN_BITS (BIN_BITS)
  ) map_i (
    .raw_code (adc_code),
    .wsel     (wsel_cfg),
    .bin_addr (bin_addr)
  );

  hist_ctrl #(
    .BIN_BITS (BIN_BITS),
    .CNT_W    (CNT_W),
    .MAX_TOP  (MAX_TOP),
    .SKIP_N   (SKIP_N)
  ) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .start     (start),
    .rdy       (adc_rdy),
    .width_sel (width_sel),
    .max_sel   (max_sel),
    .bin_in    (bin_addr),
    .ram_rdata (ram_rdata),
    .cfg_wsel  (wsel_cfg),
    .ram_addr  (mem_addr),
    .ram_we    (mem_we),
    .ram_wdata (mem_wdata),
    .out_valid (out_valid),
    .out_bin   (out_bin),
    .done      (done)
  );

  hist_ram #(
    .ADDR_W (BIN_BITS),
    .DATA_W (CNT_W)
  ) ram_i (
    .clk   (clk),
    .addr  (mem_addr),
    .we    (mem_we),
    .wdata (mem_wdata),
    .rdata (ram_rdata)
  );

  assign out_count = ram_rdata;

endmodule

// File: rtl/hist_engine_chk.sv
module hist_engine_chk #(
  parameter int BIN_BITS = 10,
  parameter int CNT_W    = 24,
  parameter int MAX_TOP  = 16384
) (
  input logic                clk,
  input logic                rst_n,
  input logic                mem_we,
  input logic [CNT_W-1:0]    mem_wdata,
  input logic                out_valid,
  input logic [BIN_BITS-1:0] out_bin,
  input logic                done
);

  localparam logic [BIN_BITS-1:0] LAST_BIN = {BIN_BITS{1'b1}};
  localparam logic [CNT_W-1:0]    TOP_CNT  = CNT_W'(MAX_TOP);

  AST_UPD_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && (mem_wdata != '0)) |-> !$past(mem_we)); // R5

  AST_WRITE_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata <= TOP_CNT)); // R7

  AST_READOUT_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> (out_bin == $past(out_bin) + BIN_BITS'(1))); // R8

  AST_READOUT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !mem_we); // R8

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(out_valid) && ($past(out_bin) == LAST_BIN))); // R9

endmodule

bind hist_engine hist_engine_chk #(
  .BIN_BITS (BIN_BITS),
  .CNT_W    (CNT_W),
  .MAX_TOP  (MAX_TOP)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .out_valid (out_valid),
  .out_bin   (out_bin),
  .done      (done)
);

// File: tb/hist_engine_tb_top.sv
module hist_engine_tb_top;

  localparam int BB    = 6;
  localparam int NB    = 1 << BB;
  localparam int CW    = 24;
  localparam int TOP   = 64;
  localparam int WDOG  = 190000;

  logic          clk;
  logic          rst_n;
  logic [17:0]   adc_code;
  logic          adc_rdy;
  logic [1:0]    width_sel;
  logic [1:0]    max_sel;
  logic          start;
  logic [BB-1:0] mem_addr;
  logic          mem_we;
  logic [CW-1:0] mem_wdata;
  logic          out_valid;
  logic [BB-1:0] out_bin;
  logic [CW-1:0] out_count;
  logic          done;

  int n_chk;
  int n_fail;
  int mdl [NB];
  bit finished;

  hist_engine #(
    .BIN_BITS (BB),
    .CNT_W    (CW),
    .MAX_TOP  (TOP),
    .SKIP_N   (11)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .adc_code  (adc_code),
    .adc_rdy   (adc_rdy),
    .width_sel (width_sel),
    .max_sel   (max_sel),
    .start     (start),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .out_valid (out_valid),
    .out_bin   (out_bin),
    .out_count (out_count),
    .done      (done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bin from the requirement text: width 18-2*sel, mask, flip top bit, keep top BB of 18.
  function automatic int exp_bin(input logic [17:0] raw, input logic [1:0] ws);
    int w;
    int c;
    w = 18 - 2 * int'(ws);
    c = int'(raw) % (1 << w);
    c = c ^ (1 << (w - 1));
    return c >> (18 - BB);
  endfunction

  function automatic int exp_limit(input logic [1:0] ms);
    return TOP / (1 << int'(ms));
  endfunction

  // mode 0: random codes, mode 1: one fixed code. disturb: mid-run start and config change.
  task automatic run_case(input logic [1:0] ws, input logic [1:0] ms, input int mode,
                          input logic [17:0] fixed, input bit disturb);
    int  lim;
    int  k;
    int  b;
    bit  hit;
    logic [17:0] raw;
    lim = exp_limit(ms);
    hit = 1'b0;
    k   = 0;
    for (int i = 0; i < NB; i++) mdl[i] = 0;

    @(negedge clk);
    width_sel = ws;
    max_sel   = ms;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // Clearing phase: pulses here must not count (R2).
    for (int i = 0; i < NB + 6; i++) begin
      adc_code = 18'($urandom);
      adc_rdy  = (i < NB - 4) ? 1'($urandom) : 1'b0;
      @(negedge clk);
    end
    adc_rdy = 1'b0;
    check(!out_valid && !done, "R2", int'(out_valid), 0);

    while (!out_valid) begin
      raw      = (mode == 1) ? fixed : 18'($urandom);
      adc_code = raw;
      adc_rdy  = ($urandom % 4) != 0;
      if (disturb && k == 30) begin
        start     = 1'b1;            // R10: ignored mid-run
        width_sel = ~ws;             // R11: not used by this run
        max_sel   = ~ms;
      end else begin
        start = 1'b0;
      end
      if (adc_rdy) begin
        if (!hit && (k % 12) == 0) begin
          b = exp_bin(raw, ws);
          mdl[b]++;
          if (mdl[b] == lim) hit = 1'b1;
        end
        k++;
      end
      @(negedge clk);
    end
    adc_rdy = 1'b0;
    start   = 1'b0;
    check(hit, "R7", int'(hit), 1);

    for (int i = 0; i < NB; i++) begin
      check(out_valid == 1'b1, "R8", int'(out_valid), 1);
      check(int'(out_bin) == i, "R8", int'(out_bin), i);
      check(int'(out_count) == mdl[i], "R6", int'(out_count), mdl[i]);
      check(!mem_we, "R8", int'(mem_we), 0);
      @(negedge clk);
    end
    check(done == 1'b1, "R9", int'(done), 1);
    check(out_valid == 1'b0, "R9", int'(out_valid), 0);
    repeat (3) @(negedge clk);
    check(done == 1'b1, "R9", int'(done), 1);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    n_chk     = 0;
    n_fail    = 0;
    finished  = 1'b0;
    rst_n     = 1'b0;
    adc_code  = '0;
    adc_rdy   = 1'b0;
    width_sel = 2'b00;
    max_sel   = 2'b00;
    start     = 1'b0;

    repeat (3) @(negedge clk);
    check(!mem_we && !out_valid && !done, "R1", int'(mem_we) + int'(out_valid) + int'(done), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!mem_we && !out_valid && !done, "R1", int'(mem_we) + int'(out_valid) + int'(done), 0);

    // R3 R4: 18-bit random codes, limit /8.
    run_case(2'b00, 2'b11, 0, '0, 1'b0);
    // R3 R11 R10: 16-bit with garbage above, limit /4, disturbed.
    run_case(2'b01, 2'b10, 0, '0, 1'b1);
    // R3: 12-bit maps everything to bin 0, limit /2.
    run_case(2'b11, 2'b01, 0, '0, 1'b0);
    // R4 R7: one fixed 14-bit code with upper garbage, full limit.
    run_case(2'b10, 2'b00, 1, 18'h3DFFF, 1'b0);
    // R4 R5: top-bit flip on a fixed 18-bit code.
    run_case(2'b00, 2'b11, 1, 18'h1F000, 1'b1);
    // R2: repeat of a random run shows bins were cleared.
    run_case(2'b00, 2'b00, 0, '0, 1'b0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule